// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Timer

This block turns a single master clock (nominally 500 kHz) into the full scan timing for a multiplexed character LCD with up to 48 common rows. Every master clock carries one dot column. A dot index and a row index go out to an external pixel source, which looks up the glyph bit. A per-column shift strobe moves that bit into the column drivers. A one-clock row latch pulse at the end of each row transfers the shifted row to the column outputs, and in the same clock edge the one-hot common outputs move to the next row.

The scan geometry follows two mode inputs. `four_line` selects 4 text lines of 40 characters or 2 lines of 80 characters, which gives rows of 200 or 400 clocks. `tall_font` selects glyphs 12 rows high instead of 8. The duty is therefore 1/16, 1/24, 1/32 or 1/48, and the frame takes 6400 or 9600 clocks (78.125 Hz or about 52.08 Hz at 500 kHz). The block samples the mode inputs in the first clock after reset and then only at frame boundaries, so a frame never mixes geometries.

A frame-alternating AC drive signal inverts at every frame start. A blink phase flag inverts once every `BLINK_FRAMES` frames (32 by default). At 500 kHz this gives 409.6 ms with 8-row glyphs and 614.4 ms with 12-row glyphs.

Top module: `lcd_scan_timer`

## Requirements
- R1: While reset is low, `com_out` has only bit 0 set, `row_idx` and `dot_idx` are 0, and `ac_phase`, `blink_phase`, `seg_clk` and `row_latch` are all 0.
- R2: `dot_idx` increases by one per clock from 0. A row is 400 clocks (dot 0..399) when `four_line`=0 and 200 clocks (dot 0..199) when `four_line`=1. After the last dot of a row it returns to 0.
- R3: The rows per frame are 16 for `four_line`=0 and `tall_font`=0, 24 for 0/1, 32 for 1/0 and 48 for 1/1. `row_idx` steps 0,1,…,duty-1 and then returns to 0.
- R4: `row_latch` is high for exactly one clock per row, the clock in which `dot_idx` holds the row's last dot.
- R5: `com_out` is one-hot with bit `row_idx` set. It changes only on the clock edge that ends a latch clock: it moves up by one bit, or goes back to bit 0 after the last row of the frame.
- R6: Bits of `com_out` at or above the active duty count are never set.
- R7: `ac_phase` inverts on the edge that starts each new frame and holds its value at all other times.
- R8: `blink_phase` inverts at the start of every `BLINK_FRAMES`-th frame and at no other time. With the default of 32 this is 409.6 ms (8-row glyphs) or 614.4 ms (12-row glyphs) at 500 kHz.
- R9: The mode inputs are sampled on the first clock edge after reset and on each frame-end edge. A change in the middle of a frame has no effect until the next frame starts.
- R10: `seg_clk` is low in reset and is high in every clock after the first edge, one shift strobe per dot column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one dot column per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| four_line | input | 1 | 1: 4 lines of 40 characters; 0: 2 lines of 80 |
| tall_font | input | 1 | 1: 12-row glyphs; 0: 8-row glyphs |
| seg_clk | output | 1 | Column shift strobe, valid per master clock |
| row_latch | output | 1 | One-clock pulse in the last clock of each row |
| ac_phase | output | 1 | Frame-alternating AC drive polarity |
| blink_phase | output | 1 | Blink phase flag |
| com_out | output | MAX_ROWS (48) | One-hot common row drive |
| row_idx | output | ROW_W (6) | Current common row to the pixel source |
| dot_idx | output | DOT_W (9) | Current dot column to the pixel source |

## Verification
The bound checker checks the local rules on every cycle. These are the one-hot commons and their agreement with `row_idx`, the single-clock latch, the dot and row step patterns, and that the AC and blink flags change only at a row-0 start. Properties that depend on a whole frame or on several frames can only be shown by the bench scenarios. These are the exact row length and duty for each of the four mode pairs, the frame-aligned sampling of a mode change made mid-frame, the frame-count period of the blink flag, and the commons above the duty staying idle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   // Scan geometry selected by the two mode inputs
   typedef struct packed {
      logic four_line;
      logic tall_font;
   } scan_cfg_t;

   // Rows per frame: text lines times glyph height
   function automatic int unsigned rows_per_frame(input logic four_line,
                                                  input logic tall_font,
                                                  input int unsigned short_h,
                                                  input int unsigned tall_h);
      int unsigned lines;
      lines = four_line ? 4 : 2;
      return lines * (tall_font ? tall_h : short_h);
   endfunction

endpackage

// File: rtl/lcd_scan_cfg.sv
module lcd_scan_cfg
   import lcd_scan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      four_line,
   input  logic      tall_font,
   input  logic      frame_end,
   output scan_cfg_t cfg
);

   logic init_q;

   // Sample the mode pins once after reset, then only when a frame wraps
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b1;
         cfg    <= '0;
      end else begin
         init_q <= 1'b0;
         if (init_q || frame_end) begin
            cfg.four_line <= four_line;
            cfg.tall_font <= tall_font;
         end
      end
   end

endmodule

// File: rtl/lcd_dot_counter.sv
module lcd_dot_counter #(
   parameter int unsigned ROW_LEN_WIDE   = 400,
   parameter int unsigned ROW_LEN_NARROW = 200,
   parameter int unsigned DOT_W          = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             narrow,
   output logic [DOT_W-1:0] dot_q,
   output logic             row_end
);

   localparam logic [DOT_W-1:0] LAST_WIDE   = DOT_W'(ROW_LEN_WIDE - 1);
   localparam logic [DOT_W-1:0] LAST_NARROW = DOT_W'(ROW_LEN_NARROW - 1);

   logic [DOT_W-1:0] last_dot;

   assign last_dot = narrow ? LAST_NARROW : LAST_WIDE;
   assign row_end  = (dot_q == last_dot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dot_q <= '0;
      end else if (row_end) begin
         dot_q <= '0;
      end else begin
         dot_q <= dot_q + 1'b1;
      end
   end

endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
   import lcd_scan_pkg::*;
#(
   parameter int unsigned MAX_ROWS    = 48,
   parameter int unsigned ROW_W       = 6,
   parameter int unsigned GLYPH_SHORT = 8,
   parameter int unsigned GLYPH_TALL  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  scan_cfg_t           cfg,
   input  logic                row_end,
   output logic [ROW_W-1:0]    row_q,
   output logic [MAX_ROWS-1:0] com_q,
   output logic                frame_end
);

   localparam logic [ROW_W-1:0] LAST_2S = ROW_W'(rows_per_frame(1'b0, 1'b0, GLYPH_SHORT, GLYPH_TALL) - 1);
   localparam logic [ROW_W-1:0] LAST_2T = ROW_W'(rows_per_frame(1'b0, 1'b1, GLYPH_SHORT, GLYPH_TALL) - 1);
   localparam logic [ROW_W-1:0] LAST_4S = ROW_W'(rows_per_frame(1'b1, 1'b0, GLYPH_SHORT, GLYPH_TALL) - 1);
   localparam logic [ROW_W-1:0] LAST_4T = ROW_W'(rows_per_frame(1'b1, 1'b1, GLYPH_SHORT, GLYPH_TALL) - 1);

   logic [ROW_W-1:0] last_row;

   always_comb begin
      unique case ({cfg.four_line, cfg.tall_font})
         2'b00:   last_row = LAST_2S;
         2'b01:   last_row = LAST_2T;
         2'b10:   last_row = LAST_4S;
         default: last_row = LAST_4T;
      endcase
   end

   assign frame_end = row_end && (row_q == last_row);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (frame_end) begin
         row_q <= '0;
      end else if (row_end) begin
         row_q <= row_q + 1'b1;
      end
   end

   // One flop per common line; the token walks up and re-enters at bit 0
   for (genvar i = 0; i < MAX_ROWS; i++) begin : g_com
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               com_q[i] <= 1'b1;
            end else if (row_end) begin
               com_q[i] <= frame_end;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               com_q[i] <= 1'b0;
            end else if (row_end) begin
               com_q[i] <= com_q[i-1] && !frame_end;
            end
         end
      end
   end

endmodule

// File: rtl/lcd_frame_phase.sv
module lcd_frame_phase #(
   parameter int unsigned BLINK_FRAMES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   output logic ac_q,
   output logic blink_q
);

   localparam int unsigned BF_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;
   localparam bit          POW2 = ((1 << BF_W) == BLINK_FRAMES);

   logic [BF_W-1:0] fcnt;
   logic            wrap;

   if (POW2) begin : g_pow2
      // Counter wraps naturally at the power-of-two boundary
      assign wrap = &fcnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fcnt <= '0;
         end else if (frame_end) begin
            fcnt <= fcnt + 1'b1;
         end
      end
   end else begin : g_mod
      localparam logic [BF_W-1:0] LAST_FRAME = BF_W'(BLINK_FRAMES - 1);
      assign wrap = (fcnt == LAST_FRAME);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fcnt <= '0;
         end else if (frame_end) begin
            fcnt <= wrap ? '0 : fcnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q    <= 1'b0;
         blink_q <= 1'b0;
      end else if (frame_end) begin
         ac_q <= !ac_q;
         if (wrap) begin
            blink_q <= !blink_q;
         end
      end
   end

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
   import lcd_scan_pkg::*;
#(
   parameter  int unsigned MAX_ROWS       = 48,
   parameter  int unsigned GLYPH_SHORT    = 8,
   parameter  int unsigned GLYPH_TALL     = 12,
   parameter  int unsigned COLS_WIDE      = 80,
   parameter  int unsigned COLS_NARROW    = 40,
   parameter  int unsigned DOTS_PER_CHAR  = 5,
   parameter  int unsigned BLINK_FRAMES   = 32,
   localparam int unsigned ROW_LEN_WIDE   = COLS_WIDE * DOTS_PER_CHAR,
   localparam int unsigned ROW_LEN_NARROW = COLS_NARROW * DOTS_PER_CHAR,
   localparam int unsigned DOT_W          = $clog2(ROW_LEN_WIDE),
   localparam int unsigned ROW_W          = $clog2(MAX_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                four_line,
   input  logic                tall_font,
   output logic                seg_clk,
   output logic                row_latch,
   output logic                ac_phase,
   output logic                blink_phase,
   output logic [MAX_ROWS-1:0] com_out,
   output logic [ROW_W-1:0]    row_idx,
   output logic [DOT_W-1:0]    dot_idx
);

   // Elaboration-time parameter checks
   if (MAX_ROWS < 4 * GLYPH_TALL) begin : g_bad_rows
      $error("MAX_ROWS too small for four lines of tall glyphs");
   end
   if (GLYPH_SHORT == 0 || GLYPH_SHORT > GLYPH_TALL) begin : g_bad_glyph
      $error("glyph heights out of order");
   end
   if (ROW_LEN_NARROW < 2 || ROW_LEN_NARROW > ROW_LEN_WIDE) begin : g_bad_len
      $error("narrow row must be shorter than wide row");
   end
   if (BLINK_FRAMES < 2) begin : g_bad_blink
      $error("BLINK_FRAMES must be at least 2");
   end

   scan_cfg_t cfg;
   logic      row_end;
   logic      frame_end;
   logic      seg_q;

   lcd_scan_cfg i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .four_line (four_line),
      .tall_font (tall_font),
      .frame_end (frame_end),
      .cfg       (cfg)
   );

   lcd_dot_counter #(
      .ROW_LEN_WIDE   (ROW_LEN_WIDE),
      .ROW_LEN_NARROW (ROW_LEN_NARROW),
      .DOT_W          (DOT_W)
   ) i_dots (
      .clk     (clk),
      .rst_n   (rst_n),
      .narrow  (cfg.four_line),
      .dot_q   (dot_idx),
      .row_end (row_end)
   );

   lcd_row_sequencer #(
      .MAX_ROWS    (MAX_ROWS),
      .ROW_W       (ROW_W),
      .GLYPH_SHORT (GLYPH_SHORT),
      .GLYPH_TALL  (GLYPH_TALL)
   ) i_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .row_end   (row_end),
      .row_q     (row_idx),
      .com_q     (com_out),
      .frame_end (frame_end)
   );

   lcd_frame_phase #(
      .BLINK_FRAMES (BLINK_FRAMES)
   ) i_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .ac_q      (ac_phase),
      .blink_q   (blink_phase)
   );

   // Shift strobe: quiet in reset, one strobe per dot column afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q <= 1'b0;
      end else begin
         seg_q <= 1'b1;
      end
   end

   assign seg_clk   = seg_q;
   assign row_latch = row_end;

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
   parameter int unsigned MAX_ROWS = 48,
   parameter int unsigned ROW_W    = 6,
   parameter int unsigned DOT_W    = 9,
   parameter int unsigned ROW_LEN  = 400
) (
   input logic                clk,
   input logic                rst_n,
   input logic                row_latch,
   input logic                ac_phase,
   input logic                blink_phase,
   input logic [MAX_ROWS-1:0] com_out,
   input logic [ROW_W-1:0]    row_idx,
   input logic [DOT_W-1:0]    dot_idx
);

   AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_out) == 1); // R5

   AST_COM_MATCH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(row_idx) < MAX_ROWS) && com_out[row_idx]); // R6

   AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      row_latch |=> !row_latch); // R4

   AST_DOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      row_latch |=> (dot_idx == '0)); // R2

   AST_DOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !row_latch |=> (dot_idx == ($past(dot_idx) + 1'b1))); // R2

   AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(dot_idx) < ROW_LEN); // R2

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !row_latch |=> ($stable(row_idx) && $stable(com_out))); // R5

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      row_latch |=> ((row_idx == '0) || (row_idx == ($past(row_idx) + 1'b1)))); // R3

   AST_AC_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      row_latch |=> ((row_idx == '0) == (ac_phase != $past(ac_phase)))); // R7

   AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !row_latch |=> $stable(ac_phase)); // R7

   AST_BLINK_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_phase != $past(blink_phase)) |-> (ac_phase != $past(ac_phase))); // R8

endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(
   .MAX_ROWS (MAX_ROWS),
   .ROW_W    (ROW_W),
   .DOT_W    (DOT_W),
   .ROW_LEN  (ROW_LEN_WIDE)
) i_lcd_scan_timer_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .row_latch   (row_latch),
   .ac_phase    (ac_phase),
   .blink_phase (blink_phase),
   .com_out     (com_out),
   .row_idx     (row_idx),
   .dot_idx     (dot_idx)
);

// File: tb/test_lcd_scan_timer.sv
module test_lcd_scan_timer;

   localparam int CLK_PERIOD = 2;
   localparam int BF         = 4;
   localparam int NFR        = 9;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        four_line = 1'b0;
   logic        tall_font = 1'b0;
   logic        seg_clk, row_latch, ac_phase, blink_phase;
   logic [47:0] com_out;
   logic [5:0]  row_idx;
   logic [8:0]  dot_idx;

   lcd_scan_timer #(.BLINK_FRAMES(BF)) i_lcd_scan_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .four_line   (four_line),
      .tall_font   (tall_font),
      .seg_clk     (seg_clk),
      .row_latch   (row_latch),
      .ac_phase    (ac_phase),
      .blink_phase (blink_phase),
      .com_out     (com_out),
      .row_idx     (row_idx),
      .dot_idx     (dot_idx)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      int   row;
      int   len;
      int   duty;
      int   frame;
      logic ac;
      logic blink;
   } row_item_t;

   row_item_t  exp_q[$];
   int         n_checks = 0;
   int         n_fail   = 0;
   bit         done     = 1'b0;
   bit         wd_hit   = 1'b0;
   logic [1:0] mode_seq [NFR];   // {four_line, tall_font} per frame

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Driver: push the rows one frame is expected to produce
   task automatic plan_frame(input int k, input logic [1:0] mode);
      row_item_t it;
      int duty;
      duty = (mode[1] ? 4 : 2) * (mode[0] ? 12 : 8);
      for (int r = 0; r < duty; r++) begin
         it.row   = r;
         it.len   = mode[1] ? 200 : 400;
         it.duty  = duty;
         it.frame = k;
         it.ac    = logic'(k % 2);
         it.blink = logic'((k / BF) % 2);
         exp_q.push_back(it);
      end
   endtask

   // Main sequence
   initial begin
      mode_seq = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00};
      for (int k = 0; k < NFR; k++) plan_frame(k, mode_seq[k]);
      {four_line, tall_font} = mode_seq[0];   // R9: first frame must use this, not the reset default
      repeat (3) @(negedge clk);
      check(com_out == 48'h1, "R1", "com_out in reset", com_out, 1);
      check(row_idx == 0, "R1", "row_idx in reset", row_idx, 0);
      check(dot_idx == 0, "R1", "dot_idx in reset", dot_idx, 0);
      check(ac_phase == 0, "R1", "ac_phase in reset", ac_phase, 0);
      check(blink_phase == 0, "R1", "blink_phase in reset", blink_phase, 0);
      check(seg_clk == 0, "R1", "seg_clk in reset", seg_clk, 0);
      check(row_latch == 0, "R1", "row_latch in reset", row_latch, 0);
      rst_n = 1'b1;
      wait (done || wd_hit);
      check(exp_q.size() == 0, "R3", "rows left unseen", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // Monitor: compare against the scoreboard at each row latch
   initial begin
      int pos;
      row_item_t it;
      logic [47:0] upper;
      @(posedge rst_n);
      pos = 0;
      forever begin
         @(negedge clk);
         pos++;
         check(32'(dot_idx) == pos, "R2", "dot_idx step", dot_idx, pos);
         check(com_out == (48'h1 << row_idx), "R5", "com_out vs row_idx", com_out, 48'h1 << row_idx);
         check(seg_clk == 1'b1, "R10", "seg_clk strobe", seg_clk, 1);
         if (row_latch) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected row latch", row_idx, -1);
            end else begin
               it = exp_q.pop_front();
               check(32'(row_idx) == it.row, "R3", $sformatf("row order frame %0d (R9 mode)", it.frame), row_idx, it.row);
               check(pos + 1 == it.len, "R4", $sformatf("latch at last dot frame %0d", it.frame), pos + 1, it.len);
               check(ac_phase == it.ac, "R7", $sformatf("ac_phase frame %0d", it.frame), ac_phase, it.ac);
               check(blink_phase == it.blink, "R8", $sformatf("blink frame %0d", it.frame), blink_phase, it.blink);
               upper = com_out >> it.duty;
               check(upper == '0, "R6", "commons above duty", upper, 0);
               // R9: change the mode mid-frame; it must only apply to the next frame
               if (it.row == 2 && it.frame + 1 < NFR) begin
                  {four_line, tall_font} = mode_seq[it.frame + 1];
               end
               if (exp_q.size() == 0) done = 1'b1;
            end
            pos = -1;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d rows pending", exp_q.size(), 0);
         wd_hit = 1'b1;
      end
   end

endmodule